// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timing Generator

This block turns a single start request into the strobe waveform of one read or one write access on an 8-bit asynchronous NAND flash bus. The request carries a direction bit. For a write it also carries the command-latch and address-latch selects and the byte to drive. A 32-bit timing word gives the length of every phase in controller clocks. It holds separate setup, strobe-pulse and hold counts for reads and for writes, plus a ready-sample delay for each direction that is counted in pairs of clocks. The timing word is captured when the request is accepted.

Each access runs three phases in order. During setup, chip-enable is low and the strobe is still high. During the pulse, the write or read strobe is low. During hold, the strobe is high again while data and the latch selects are still driven. On a read, the bus byte is captured on the last pulse clock. The ready/busy pin is sampled a programmed number of clocks after the strobe rises. A one-clock done pulse follows once both the hold phase and that sample are complete. A configuration input can hold chip-enable low between accesses. A synchronised copy of the ready pin is always available. A synchronous soft reset returns the block to idle.

Top module: `nand_strobe_gen`

## Requirements
- R1: After rst_n low, or on the clock after soft_rst is high, the block is idle. busy=0, done=0, nand_we_n=1, nand_re_n=1, nand_cle=0, nand_ale=0, nand_doe=0, rdata=0 and rdy_seen=0. nand_ce_n is 1 when hold_ce=0.
- R2: A write (start_rd=0) uses timing fields setup [19:16]=s, hold [23:20]=h and pulse [27:24]=p. The phases are s+1 clocks of setup with nand_we_n=1, then p+1 clocks with nand_we_n=0, then h+1 clocks of hold with nand_we_n=1. Through all three phases nand_doe=1, nand_dout equals the accepted start_wdata, and nand_cle and nand_ale follow the accepted start_cle and start_ale. nand_re_n stays 1.
- R3: A read (start_rd=1) uses setup [3:0], hold [7:4] and pulse [11:8] with the same phase order on nand_re_n. nand_we_n stays 1, and nand_doe, nand_cle and nand_ale stay 0.
- R4: On a read, rdata takes the value of nand_din on the last clock of the pulse phase. rdata changes at no other time except reset.
- R5: The ready-wait field is [15:12] for reads and [31:28] for writes, value w. nand_rdy is sampled into rdy_seen on hold clock number 2*w, where the first hold clock is number 0. If 2*w is larger than the hold length, the access is extended with strobes inactive until that clock.
- R6: busy is 1 from the clock after an accepted start up to the last clock of the access. done is 1 for exactly the following clock. An access therefore takes s+p+max(h,2*w)+3 clocks from the accepting edge to the edge that raises done. start is accepted whenever busy=0, including the done clock.
- R7: start while busy=1 is ignored and does not change the running access or its length.
- R8: nand_ce_n is 0 during setup, pulse and hold. At all other times it equals the inverse of hold_ce.
- R9: ready_stat is nand_rdy delayed by RDY_SYNC (default 2) clocks, where 1 means ready. It resets to 0.
- R10: The timing word is sampled only at the accepting edge. Changing it during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous return to idle |
| timing | input | 32 | Eight 4-bit phase fields |
| hold_ce | input | 1 | Keep chip-enable low outside accesses |
| start | input | 1 | Request one bus access |
| start_rd | input | 1 | 1 = read access, 0 = write access |
| start_cle | input | 1 | Command-latch select for a write |
| start_ale | input | 1 | Address-latch select for a write |
| start_wdata | input | 8 | Byte to drive on a write |
| nand_din | input | 8 | Bus byte from the flash |
| nand_rdy | input | 1 | Ready/busy pin, 1 = ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_dout | output | 8 | Byte driven to the flash |
| nand_doe | output | 1 | Data bus drive enable |
| rdata | output | 8 | Captured read byte |
| rdy_seen | output | 1 | Ready pin value taken at the programmed wait |
| ready_stat | output | 1 | Synchronised ready pin |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
Strobes, latch selects, data enable and busy are decoded from the phase register. They therefore change on the edge that ends the previous phase, and the setup phase begins on the clock right after the accepting edge. rdata and rdy_seen update on the edge that closes the capturing clock. done rises on the edge after the final access clock, and ready_stat lags the pin by two edges. A behavioural model advances on the same edges from clock indices within the access. Every output is compared with it a quarter period after each rising edge. Separately, the access length from the accepting edge to the done edge is checked against s+p+max(h,2w)+3, including runs where start is pulsed and the timing word is rewritten mid-access.

// File: rtl/nand_tg_pkg.sv
package nand_tg_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_PULSE = 3'd2,
      PH_HOLD  = 3'd3,
      PH_TAIL  = 3'd4
   } phase_e;

   // field index inside one direction's group of four
   localparam int unsigned FLD_SETUP = 0;
   localparam int unsigned FLD_HOLD  = 1;
   localparam int unsigned FLD_PULSE = 2;
   localparam int unsigned FLD_WAIT  = 3;
   // group base: reads use fields 0..3, writes 4..7
   localparam int unsigned GRP_RD    = 0;
   localparam int unsigned GRP_WR    = 4;
   localparam int unsigned NUM_FLD   = 8;

endpackage

// File: rtl/nand_tg_cnt.sv
module nand_tg_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   input  logic         dec,
   output logic         zero
);

   logic [W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         val_q <= '0;
      else if (clr)
         val_q <= '0;
      else if (load)
         val_q <= ld_val;
      else if (dec && (val_q != '0))
         val_q <= val_q - 1'b1;
   end

   assign zero = (val_q == '0);

endmodule

// File: rtl/nand_tg_wtmr.sv
module nand_tg_wtmr #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (step && (cnt != CNT_MAX))
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/nand_tg_sync.sv
module nand_tg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sr_q <= '0;
         else
            sr_q <= {sr_q[STAGES-2:0], d};
      end
      assign q = sr_q[STAGES-1];
   end

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
   import nand_tg_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int FIELD_W  = 4,
   parameter int RDY_SYNC = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst,
   input  logic [8*FIELD_W-1:0] timing,
   input  logic                 hold_ce,
   input  logic                 start,
   input  logic                 start_rd,
   input  logic                 start_cle,
   input  logic                 start_ale,
   input  logic [DATA_W-1:0]    start_wdata,
   input  logic [DATA_W-1:0]    nand_din,
   input  logic                 nand_rdy,
   output logic                 nand_ce_n,
   output logic                 nand_we_n,
   output logic                 nand_re_n,
   output logic                 nand_cle,
   output logic                 nand_ale,
   output logic [DATA_W-1:0]    nand_dout,
   output logic                 nand_doe,
   output logic [DATA_W-1:0]    rdata,
   output logic                 rdy_seen,
   output logic                 ready_stat,
   output logic                 busy,
   output logic                 done
);

   localparam int WT_W = FIELD_W + 2;

   // elaboration-time parameter checks
   if (FIELD_W < 2 || FIELD_W > 6) begin : g_bad_field
      $error("FIELD_W must lie in 2..6");
   end
   if (DATA_W != 8 && DATA_W != 16) begin : g_bad_data
      $error("DATA_W must be 8 or 16");
   end
   if (RDY_SYNC < 0 || RDY_SYNC > 3) begin : g_bad_sync
      $error("RDY_SYNC must lie in 0..3");
   end

   // unpack the timing word
   logic [FIELD_W-1:0] fld [NUM_FLD];
   for (genvar gi = 0; gi < NUM_FLD; gi++) begin : g_fld
      assign fld[gi] = timing[gi*FIELD_W +: FIELD_W];
   end

   logic [2:0] grp;
   assign grp = start_rd ? 3'(GRP_RD) : 3'(GRP_WR);

   // per-access state
   phase_e             ph_q, ph_d;
   logic               rd_q, cle_q, ale_q;
   logic [DATA_W-1:0]  wd_q;
   logic [FIELD_W-1:0] pulse_q, hold_q, wait_q;
   logic               done_q, seen_q;
   logic [DATA_W-1:0]  rdata_q;

   logic               accept;
   logic               pc_load, pc_dec, pc_zero;
   logic [FIELD_W-1:0] pc_val;
   logic               wt_clr, wt_step;
   logic [WT_W-1:0]    wt_cnt, wt_tgt;
   logic               wt_hit, wt_met, finish, capture, sample;

   assign accept  = (ph_q == PH_IDLE) && start;
   assign wt_tgt  = {1'b0, wait_q, 1'b0};
   assign wt_hit  = (wt_cnt == wt_tgt);
   assign wt_met  = (wt_cnt >= wt_tgt);
   assign pc_dec  = (ph_q == PH_SETUP) || (ph_q == PH_PULSE) || (ph_q == PH_HOLD);
   assign wt_clr  = soft_rst || ((ph_q == PH_PULSE) && pc_zero);
   assign wt_step = (ph_q == PH_HOLD) || (ph_q == PH_TAIL);
   assign capture = (ph_q == PH_PULSE) && pc_zero && rd_q;
   assign sample  = wt_step && wt_hit;
   assign finish  = ((ph_q == PH_HOLD) && pc_zero && wt_met) ||
                    ((ph_q == PH_TAIL) && wt_hit);

   always_comb begin
      ph_d    = ph_q;
      pc_load = 1'b0;
      pc_val  = '0;
      unique case (ph_q)
         PH_IDLE: begin
            if (start) begin
               ph_d    = PH_SETUP;
               pc_load = 1'b1;
               pc_val  = fld[grp + 3'(FLD_SETUP)];
            end
         end
         PH_SETUP: begin
            if (pc_zero) begin
               ph_d    = PH_PULSE;
               pc_load = 1'b1;
               pc_val  = pulse_q;
            end
         end
         PH_PULSE: begin
            if (pc_zero) begin
               ph_d    = PH_HOLD;
               pc_load = 1'b1;
               pc_val  = hold_q;
            end
         end
         PH_HOLD: begin
            if (pc_zero)
               ph_d = wt_met ? PH_IDLE : PH_TAIL;
         end
         PH_TAIL: begin
            if (wt_hit)
               ph_d = PH_IDLE;
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         rd_q    <= 1'b0;
         cle_q   <= 1'b0;
         ale_q   <= 1'b0;
         wd_q    <= '0;
         pulse_q <= '0;
         hold_q  <= '0;
         wait_q  <= '0;
         done_q  <= 1'b0;
         seen_q  <= 1'b0;
         rdata_q <= '0;
      end else if (soft_rst) begin
         ph_q    <= PH_IDLE;
         done_q  <= 1'b0;
         seen_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         ph_q   <= ph_d;
         done_q <= finish;
         if (accept) begin
            rd_q    <= start_rd;
            cle_q   <= start_cle & ~start_rd;
            ale_q   <= start_ale & ~start_rd;
            wd_q    <= start_wdata;
            pulse_q <= fld[grp + 3'(FLD_PULSE)];
            hold_q  <= fld[grp + 3'(FLD_HOLD)];
            wait_q  <= fld[grp + 3'(FLD_WAIT)];
         end
         if (capture)
            rdata_q <= nand_din;
         if (sample)
            seen_q <= nand_rdy;
      end
   end

   nand_tg_cnt #(.W(FIELD_W)) i_phase_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (soft_rst),
      .load   (pc_load),
      .ld_val (pc_val),
      .dec    (pc_dec),
      .zero   (pc_zero)
   );

   nand_tg_wtmr #(.W(WT_W)) i_wait_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wt_clr),
      .step  (wt_step),
      .cnt   (wt_cnt)
   );

   nand_tg_sync #(.STAGES(RDY_SYNC)) i_rdy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nand_rdy),
      .q     (ready_stat)
   );

   // strobe decode from the phase register
   logic driving;
   assign driving   = pc_dec;
   assign nand_ce_n = ~(driving | hold_ce);
   assign nand_we_n = ~((ph_q == PH_PULSE) & ~rd_q);
   assign nand_re_n = ~((ph_q == PH_PULSE) &  rd_q);
   assign nand_cle  = driving & cle_q;
   assign nand_ale  = driving & ale_q;
   assign nand_doe  = driving & ~rd_q;
   assign nand_dout = wd_q;
   assign rdata     = rdata_q;
   assign rdy_seen  = seen_q;
   assign busy      = (ph_q != PH_IDLE);
   assign done      = done_q;

endmodule

// File: rtl/nand_tg_chk.sv
module nand_tg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       soft_rst,
   input logic       start,
   input logic       nand_ce_n,
   input logic       nand_we_n,
   input logic       nand_re_n,
   input logic       nand_doe,
   input logic [7:0] rdata,
   input logic       busy,
   input logic       done
);

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n)); // R3

   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_doe); // R3

   AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |-> nand_doe); // R2

   AST_STROBE_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R6

   AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!busy && !done && nand_we_n && nand_re_n)); // R1

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !soft_rst) |=> (busy || done)); // R7

   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (nand_re_n && $past(nand_re_n) && !$past(soft_rst)) |-> $stable(rdata)); // R4

endmodule

bind nand_strobe_gen nand_tg_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .soft_rst  (soft_rst),
   .start     (start),
   .nand_ce_n (nand_ce_n),
   .nand_we_n (nand_we_n),
   .nand_re_n (nand_re_n),
   .nand_doe  (nand_doe),
   .rdata     (rdata),
   .busy      (busy),
   .done      (done)
);

// File: tb/test_nand_strobe_gen.sv
`timescale 1ns/1ps
module test_nand_strobe_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [31:0] timing = '0;
   logic        hold_ce = 1'b0;
   logic        start = 1'b0;
   logic        start_rd = 1'b0;
   logic        start_cle = 1'b0;
   logic        start_ale = 1'b0;
   logic [7:0]  start_wdata = '0;
   logic [7:0]  nand_din = '0;
   logic        nand_rdy = 1'b0;
   logic        nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_doe;
   logic [7:0]  nand_dout, rdata;
   logic        rdy_seen, ready_stat, busy, done;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10 clk = ~clk; // 50 MHz

   nand_strobe_gen i_nand_strobe_gen (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .timing(timing),
      .hold_ce(hold_ce), .start(start), .start_rd(start_rd),
      .start_cle(start_cle), .start_ale(start_ale), .start_wdata(start_wdata),
      .nand_din(nand_din), .nand_rdy(nand_rdy), .nand_ce_n(nand_ce_n),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_cle(nand_cle),
      .nand_ale(nand_ale), .nand_dout(nand_dout), .nand_doe(nand_doe),
      .rdata(rdata), .rdy_seen(rdy_seen), .ready_stat(ready_stat),
      .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   function automatic int fld(input logic [31:0] t, input int idx);
      return int'((t >> (4*idx)) & 32'hF);
   endfunction

   function automatic logic [31:0] mk_tim(input int rs, rh, rp, rw, ws, wh, wp, ww);
      return {4'(ww), 4'(wp), 4'(wh), 4'(ws), 4'(rw), 4'(rp), 4'(rh), 4'(rs)};
   endfunction

   // pin stimulus, independent of the access sequence
   int pat = 0;
   always @(negedge clk) begin
      pat++;
      nand_din <= 8'(pat * 37 + 5);
      nand_rdy <= (pat % 3) != 0;
   end

   // behavioural reference model, compared every clock
   bit          mb, md, mrd, mcl, mal, mseen, sy1, sy2;
   int          k, ms, mp, mh, mw;
   logic [7:0]  mwd, mrdat;
   bit          cmp_en = 0;

   always @(posedge clk) begin
      int t, endt, ph, base;
      bit drv;
      if (!rst_n) begin
         mb = 0; md = 0; mrd = 0; mcl = 0; mal = 0; mseen = 0;
         sy1 = 0; sy2 = 0; k = 0; mwd = 0; mrdat = 0;
      end else begin
         sy2 = sy1; sy1 = nand_rdy;
         if (soft_rst) begin
            mb = 0; md = 0; mrdat = 0; mseen = 0;
         end else begin
            md = 0;
            if (mb) begin
               t = k - (ms + mp + 2);
               endt = (mh > 2*mw) ? mh : 2*mw;
               if (mrd && k == ms + mp + 1) mrdat = nand_din;
               if (t == 2*mw) mseen = nand_rdy;
               if (t == endt) begin mb = 0; md = 1; end
               k++;
            end else if (start) begin
               base = start_rd ? 0 : 4;
               ms = fld(timing, base); mh = fld(timing, base + 1);
               mp = fld(timing, base + 2); mw = fld(timing, base + 3);
               mrd = start_rd; mcl = start_cle & !start_rd;
               mal = start_ale & !start_rd; mwd = start_wdata;
               mb = 1; k = 0;
            end
         end
      end
      #5;
      if (cmp_en) begin
         if (!mb) ph = 0;
         else if (k <= ms) ph = 1;
         else if (k <= ms + mp + 1) ph = 2;
         else if (k - (ms + mp + 2) <= mh) ph = 3;
         else ph = 4;
         drv = (ph >= 1 && ph <= 3);
         chk(nand_ce_n == !(drv || hold_ce), "R8 ce_n", nand_ce_n, !(drv || hold_ce));
         chk(nand_we_n == !(ph == 2 && !mrd), "R2 we_n", nand_we_n, !(ph == 2 && !mrd));
         chk(nand_re_n == !(ph == 2 && mrd), "R3 re_n", nand_re_n, !(ph == 2 && mrd));
         chk(nand_cle == (drv && mcl), "R2 cle", nand_cle, drv && mcl);
         chk(nand_ale == (drv && mal), "R2 ale", nand_ale, drv && mal);
         chk(nand_doe == (drv && !mrd), "R3 doe", nand_doe, drv && !mrd);
         if (drv && !mrd) chk(nand_dout == mwd, "R2 dout", nand_dout, mwd);
         chk(busy == mb, "R6 busy", busy, mb);
         chk(done == md, "R6 done", done, md);
         chk(rdata == mrdat, "R4 rdata", rdata, mrdat);
         chk(rdy_seen == mseen, "R5 rdy_seen", rdy_seen, mseen);
         chk(ready_stat == sy2, "R9 ready_stat", ready_stat, sy2);
      end
   end

   // one access; returns clocks from accepting edge to done edge
   task automatic access(input bit rd, input bit cl, input bit al, input logic [7:0] wd,
                         input bit poke, output int len);
      @(negedge clk);
      start = 1; start_rd = rd; start_cle = cl; start_ale = al; start_wdata = wd;
      @(negedge clk);
      start = 0;
      len = 0;
      while (!done && len < 200) begin
         @(negedge clk);
         len++;
         if (poke && len == 2) begin
            start = 1; start_rd = !rd; timing = ~timing;
         end else begin
            start = 0;
         end
      end
   endtask

   function automatic int exp_len(input logic [31:0] t, input bit rd);
      int b, w2, h;
      b = rd ? 0 : 4;
      h = fld(t, b + 1);
      w2 = 2 * fld(t, b + 3);
      return fld(t, b) + fld(t, b + 2) + ((h > w2) ? h : w2) + 3;
   endfunction

   initial begin
      int len, el;
      logic [31:0] tsave;
      repeat (3) @(negedge clk);
      rst_n = 1;
      cmp_en = 1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done && nand_we_n && nand_re_n && nand_ce_n && !nand_doe,
          "R1 reset idle", {busy, done, nand_we_n, nand_re_n, nand_ce_n, nand_doe}, 6'b001110);

      // write, command latch, hold longer than wait
      timing = mk_tim(0, 0, 0, 0, 1, 2, 3, 0);
      access(0, 1, 0, 8'hA5, 0, len);
      chk(len == exp_len(timing, 0), "R2 write length", len, exp_len(timing, 0));

      // write, address latch, ready wait beyond hold (tail)
      timing = mk_tim(0, 0, 0, 0, 0, 1, 0, 5);
      access(0, 0, 1, 8'h3C, 0, len);
      chk(len == exp_len(timing, 0), "R5 tail length", len, exp_len(timing, 0));

      // minimal read
      timing = mk_tim(0, 0, 0, 0, 7, 7, 7, 7);
      access(1, 1, 1, 8'hFF, 0, len);
      chk(len == 3, "R3 min read length", len, 3);

      // read with longer pulse, wait inside hold
      timing = mk_tim(2, 6, 4, 2, 0, 0, 0, 0);
      access(1, 0, 0, 8'h00, 0, len);
      chk(len == exp_len(timing, 1), "R4 read length", len, exp_len(timing, 1));

      // start and timing change while busy
      timing = mk_tim(3, 3, 5, 1, 3, 4, 5, 2);
      tsave = timing;
      access(0, 1, 0, 8'h5A, 1, len);
      el = exp_len(tsave, 0);
      chk(len == el, "R7 R10 ignored mid-access", len, el);
      timing = tsave;
      access(1, 0, 0, 8'h00, 1, len);
      el = exp_len(tsave, 1);
      chk(len == el, "R10 read timing latched", len, el);
      timing = tsave;

      // chip enable held across back-to-back accesses
      hold_ce = 1;
      timing = mk_tim(1, 1, 1, 0, 1, 1, 1, 0);
      access(0, 0, 1, 8'h11, 0, len);
      chk(nand_ce_n == 0, "R8 ce held after done", nand_ce_n, 0);
      access(1, 0, 0, 8'h00, 0, len);
      hold_ce = 0;
      @(negedge clk);
      chk(nand_ce_n == 1, "R8 ce released", nand_ce_n, 1);

      // largest fields
      timing = 32'hFFFF_FFFF;
      access(1, 0, 0, 8'h00, 0, len);
      chk(len == exp_len(timing, 1), "R6 max read length", len, exp_len(timing, 1));
      access(0, 1, 1, 8'hC3, 0, len);
      chk(len == exp_len(timing, 0), "R6 max write length", len, exp_len(timing, 0));

      // soft reset mid-access
      @(negedge clk);
      start = 1; start_rd = 0; start_cle = 1; start_ale = 0; start_wdata = 8'h77;
      @(negedge clk);
      start = 0;
      repeat (20) @(negedge clk);
      soft_rst = 1;
      @(negedge clk);
      soft_rst = 0;
      chk(!busy && nand_we_n && nand_re_n && nand_ce_n && !nand_doe && !nand_cle && rdata == 0,
          "R1 soft reset idle", {busy, nand_we_n, nand_re_n, nand_ce_n, nand_doe}, 5'b01110);
      repeat (5) @(negedge clk);
      chk(!done, "R1 no done after soft reset", done, 0);

      // back to back reads after soft reset
      timing = mk_tim(1, 0, 2, 1, 0, 0, 0, 0);
      access(1, 0, 0, 8'h00, 0, len);
      chk(len == exp_len(timing, 1), "R6 read after soft reset", len, exp_len(timing, 1));
      @(negedge clk);
      start = 1; start_rd = 1;
      @(negedge clk);
      start = 0;
      repeat (12) @(negedge clk);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule